// File: doc/BRIEF.md
# Host-Side Serial Port Interrupt Identification

This block serves the host side of a bridge in which a local processor emulates a classic serial port. It holds the interrupt enable register, which the host writes and both sides read. From four cause inputs it builds the interrupt identification value and drives the host interrupt line. The four causes are line status, received data, transmitter holding empty and modem status.

Line-status, received-data and modem-status causes arrive as level inputs from the neighbouring status logic. The transmitter-empty cause is latched inside the block. A pulse on `thre_evt_i` sets it. The cause clears when the host writes the holding register. It also clears when the host finishes reading the identification value while that cause was the one reported.

While the host holds `iir_rd_i` high, the identification output is frozen at the value it had in the first cycle of the access. The latched transmitter-empty cause is frozen as well. Events and holding-register writes that arrive during the access are recorded and applied when the access ends. The read that is in progress never acknowledges them.

Top module: `uart_iid_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the identification value reads 0x01 and `irq_o` is low.
- R2: A host write to the enable register loads bits 3:0 from the write data. Bits 7:4 always read 0 on `ier_o`, so writing 0xFF reads back as 0x0F.
- R3: Identification bit 0 is active low. It is 0 exactly when at least one enabled cause is pending, and 1 (value 0x01) when none is.
- R4: Enabled causes are ranked from highest to lowest as line status, received data, transmitter empty and modem status. The identification values are 0x06, 0x04, 0x02 and 0x00 respectively.
- R5: Enable bit 0 gates received data, bit 1 transmitter empty, bit 2 line status and bit 3 modem status. A cause whose enable bit is 0 has no effect on the output.
- R6: `irq_o` is always the inverse of identification bit 0.
- R7: While `iir_rd_i` stays high, `iir_o` holds the value it showed in the first cycle of the access, even when cause inputs change.
- R8: A transmitter-empty event that arrives during an access is not shown during that access. It appears once the access ends, and that access's read does not clear it.
- R9: An access that reported the transmitter-empty cause (0x02) clears that cause when it ends.
- R10: A host holding-register write clears the transmitter-empty cause. An access that reported a different cause leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ier_we_i | input | 1 | Host write strobe for the enable register |
| ier_wdata_i | input | 8 | Host write data for the enable register |
| ier_o | output | 8 | Enable register value, readable by host and processor |
| iir_rd_i | input | 1 | High for the duration of a host identification read |
| thr_we_i | input | 1 | Host write to the transmit holding register |
| rda_i | input | 1 | Received-data-available cause (level) |
| thre_evt_i | input | 1 | Pulse: transmit holding register became empty |
| lsr_i | input | 1 | Line-status cause (level) |
| msr_i | input | 1 | Modem-status cause (level) |
| iir_o | output | 8 | Interrupt identification value |
| irq_o | output | 1 | Host interrupt request |

## Verification
The bench builds the block with its default 8-bit data width and 4-bit enable field. These values bring every one of the sixteen enable patterns within reach, together with the always-zero upper enable bits. A vector table covers the enable and cause combinations that decide the priority. Directed sequences then open and close host reads around transmitter-empty events, so that freeze, deferral and read acknowledgement can be observed at the outputs.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  localparam int unsigned NSRC = 4;
  // cause index equals enable bit
  localparam int unsigned SRC_RDA  = 0;
  localparam int unsigned SRC_THRE = 1;
  localparam int unsigned SRC_LSR  = 2;
  localparam int unsigned SRC_MSR  = 3;
  localparam logic [2:0] ID_LSR  = 3'b011;
  localparam logic [2:0] ID_RDA  = 3'b010;
  localparam logic [2:0] ID_THRE = 3'b001;
  localparam logic [2:0] ID_MSR  = 3'b000;
endpackage

// File: rtl/uart_iid_ier.sv
module uart_iid_ier #(
  parameter int unsigned DW   = 8,
  parameter int unsigned EN_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [EN_W-1:0] en_o,
  output logic [DW-1:0] ier_o
);
  localparam int unsigned PAD = DW - EN_W;

  logic [EN_W-1:0] ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ier_q <= '0;
    else if (we_i) ier_q <= wdata_i[EN_W-1:0];
  end

  assign en_o  = ier_q;
  assign ier_o = {{PAD{1'b0}}, ier_q};

  p_ier_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ier_o[EN_W-1:0] == $past(wdata_i[EN_W-1:0]));
endmodule

// File: rtl/uart_iid_thre.sv
module uart_iid_thre (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic thr_we_i,
  input  logic acc_i,
  input  logic end_i,
  input  logic rep_i,
  output logic pend_o
);
  logic pend_q, evt_seen_q, wr_seen_q;
  logic kept;

  // state surviving the finished access
  assign kept = (pend_q & ~rep_i & ~wr_seen_q) | evt_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      evt_seen_q <= 1'b0;
      wr_seen_q  <= 1'b0;
    end else if (acc_i) begin
      evt_seen_q <= (evt_seen_q & ~thr_we_i) | evt_i;
      wr_seen_q  <= wr_seen_q | thr_we_i;
    end else if (end_i) begin
      pend_q     <= (kept & ~thr_we_i) | evt_i;
      evt_seen_q <= 1'b0;
      wr_seen_q  <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~thr_we_i) | evt_i;
    end
  end

  assign pend_o = pend_q;

  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> $stable(pend_o));
  p_read_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && rep_i && !evt_seen_q && !evt_i) |=> !pend_o);
  p_thr_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !end_i && thr_we_i && !evt_i) |=> !pend_o);
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_iid_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] cause_i,
  input  logic [NSRC-1:0] en_i,
  output logic [DW-1:0]   iid_o
);
  logic [NSRC-1:0] act;

  for (genvar g = 0; g < NSRC; g++) begin : g_mask
    assign act[g] = cause_i[g] & en_i[g];
  end

  always_comb begin
    iid_o    = '0;
    iid_o[0] = 1'b1;
    if (act[SRC_LSR]) begin
      iid_o[3:1] = ID_LSR;  iid_o[0] = 1'b0;
    end else if (act[SRC_RDA]) begin
      iid_o[3:1] = ID_RDA;  iid_o[0] = 1'b0;
    end else if (act[SRC_THRE]) begin
      iid_o[3:1] = ID_THRE; iid_o[0] = 1'b0;
    end else if (act[SRC_MSR]) begin
      iid_o[3:1] = ID_MSR;  iid_o[0] = 1'b0;
    end
  end

  p_lsr_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i[SRC_LSR] && en_i[SRC_LSR]) |-> iid_o[3:0] == 4'h6);
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_i & en_i) == '0) |-> iid_o[0]);
endmodule

// File: rtl/uart_iid_ctrl.sv
module uart_iid_ctrl
  import uart_iid_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned EN_W = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ier_we_i,
  input  logic [DW-1:0] ier_wdata_i,
  output logic [DW-1:0] ier_o,
  input  logic          iir_rd_i,
  input  logic          thr_we_i,
  input  logic          rda_i,
  input  logic          thre_evt_i,
  input  logic          lsr_i,
  input  logic          msr_i,
  output logic [DW-1:0] iir_o,
  output logic          irq_o
);
  logic [EN_W-1:0] en;
  logic [DW-1:0]   live, snap_q;
  logic            rd_q, frozen, acc_end, rep_thre, thre_pend;
  logic [NSRC-1:0] cause;

  uart_iid_ier #(.DW(DW), .EN_W(EN_W)) u_ier (
    .clk_i, .rst_ni, .we_i(ier_we_i), .wdata_i(ier_wdata_i),
    .en_o(en), .ier_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      snap_q <= {{(DW-1){1'b0}}, 1'b1};
    end else begin
      rd_q <= iir_rd_i;
      if (!frozen) snap_q <= live;
    end
  end

  assign frozen   = iir_rd_i & rd_q;
  assign acc_end  = rd_q & ~iir_rd_i;
  assign rep_thre = (snap_q[3:0] == {ID_THRE, 1'b0});

  uart_iid_thre u_thre (
    .clk_i, .rst_ni, .evt_i(thre_evt_i), .thr_we_i,
    .acc_i(iir_rd_i), .end_i(acc_end), .rep_i(rep_thre), .pend_o(thre_pend)
  );

  always_comb begin
    cause           = '0;
    cause[SRC_RDA]  = rda_i;
    cause[SRC_THRE] = thre_pend;
    cause[SRC_LSR]  = lsr_i;
    cause[SRC_MSR]  = msr_i;
  end

  uart_iid_prio #(.DW(DW)) u_prio (
    .clk_i, .rst_ni, .cause_i(cause), .en_i(en[NSRC-1:0]), .iid_o(live)
  );

  assign iir_o = frozen ? snap_q : live;
  assign irq_o = ~iir_o[0];

  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && $past(iir_rd_i)) |-> $stable(iir_o));
  p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != iir_o[0]);
endmodule

// File: tb/tb_uart_iid_ctrl.sv
module tb_uart_iid_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ier_we = 0, iir_rd = 0, thr_we = 0, rda = 0, thre_evt = 0, lsr = 0, msr = 0;
  logic [7:0] ier_wdata = '0;
  logic [7:0] ier_o, iir_o;
  logic irq_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_iid_ctrl dut (
    .clk_i(clk), .rst_ni, .ier_we_i(ier_we), .ier_wdata_i(ier_wdata), .ier_o,
    .iir_rd_i(iir_rd), .thr_we_i(thr_we), .rda_i(rda), .thre_evt_i(thre_evt),
    .lsr_i(lsr), .msr_i(msr), .iir_o, .irq_o
  );

  // {ier[3:0], lsr, rda, msr, expected iir}
  localparam logic [14:0] VEC [9] = '{
    {4'hF, 3'b000, 8'h01}, {4'hF, 3'b100, 8'h06}, {4'hF, 3'b111, 8'h06},
    {4'hF, 3'b011, 8'h04}, {4'hF, 3'b001, 8'h00}, {4'h7, 3'b001, 8'h01},
    {4'hE, 3'b110, 8'h06}, {4'hA, 3'b011, 8'h00}, {4'hB, 3'b111, 8'h04}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic chk_iir(input string tag, input logic [7:0] exp);
    chk(tag, iir_o, exp);
    chk({tag, " R6 irq"}, {7'b0, irq_o}, {7'b0, ~exp[0]});
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_we = 1; ier_wdata = v; cyc(); ier_we = 0;
  endtask

  task automatic pulse_evt(); thre_evt = 1; cyc(); thre_evt = 0; endtask
  task automatic pulse_thr(); thr_we = 1; cyc(); thr_we = 0; endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(); cyc(); rst_ni = 1; cyc();
    chk("R1 ier reset", ier_o, 8'h00);
    chk_iir("R1 iir reset", 8'h01);

    wr_ier(8'hFF);
    chk("R2 upper enable bits zero", ier_o, 8'h0F);
    wr_ier(8'h05);
    chk("R2 enable load", ier_o, 8'h05);

    for (int i = 0; i < 9; i++) begin
      ier_we = 1; ier_wdata = {4'h0, VEC[i][14:11]};
      lsr = VEC[i][10]; rda = VEC[i][9]; msr = VEC[i][8];
      cyc(); ier_we = 0;
      chk_iir($sformatf("R3 R4 R5 vector %0d", i), VEC[i][7:0]);
    end
    lsr = 0; rda = 0; msr = 0;

    // transmitter empty, cleared by holding write
    wr_ier(8'h02);
    pulse_evt();
    chk_iir("R4 thre code", 8'h02);
    pulse_thr();
    chk_iir("R10 thr write clears", 8'h01);

    // freeze against a level cause
    wr_ier(8'h0F);
    iir_rd = 1; cyc();
    lsr = 1; cyc();
    chk_iir("R7 frozen during read", 8'h01);
    cyc();
    chk_iir("R7 still frozen", 8'h01);
    iir_rd = 0; cyc();
    chk_iir("R7 live after read", 8'h06);
    lsr = 0; cyc();

    // event during read deferred
    wr_ier(8'h02);
    iir_rd = 1; cyc();
    pulse_evt();
    chk_iir("R8 event hidden during read", 8'h01);
    iir_rd = 0; cyc();
    chk_iir("R8 event shown after read", 8'h02);

    // reported read with new event: not acknowledged
    iir_rd = 1; cyc();
    pulse_evt();
    chk_iir("R8 frozen on thre", 8'h02);
    iir_rd = 0; cyc();
    chk_iir("R8 new event survives read", 8'h02);

    // reported read clears
    iir_rd = 1; cyc(); cyc();
    iir_rd = 0; cyc();
    chk_iir("R9 read clears thre", 8'h01);

    // read of another cause leaves thre pending
    wr_ier(8'h0F);
    rda = 1;
    pulse_evt();
    chk_iir("R4 rda over thre", 8'h04);
    iir_rd = 1; cyc(); cyc();
    iir_rd = 0; cyc();
    chk_iir("R10 rda still reported", 8'h04);
    rda = 0; cyc();
    chk_iir("R10 thre kept after other read", 8'h02);
    pulse_thr();
    chk_iir("R10 cleared by write", 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule